// File: doc/BRIEF.md
# Electron/photon candidate judge for one trigger tower

This block takes one central calorimeter trigger tower together with its eight surrounding towers and decides whether the centre holds an electron/photon candidate. Every tower arrives with an 8-bit electromagnetic (EM) transverse energy, an 8-bit hadronic transverse energy and a single fine-grain bit that has already been computed upstream. Two configuration inputs set the allowed hadronic fraction and the threshold for a quiet corner.

The result is a hit flag, a candidate rank and an isolated flag. They appear two clock cycles after the input, with a valid bit that travels alongside. The block is meant to be repeated once per tower position by an enclosing scanner. That scanner, and any sorting of candidates, sit outside this block.

Towers are packed into the buses in row-major order. Tower 0 is the north-west corner and tower 8 is the south-east corner. Tower 4 is the centre, tower 1 is north, tower 3 is west, tower 5 is east and tower 7 is south. Tower i occupies bits [8i+7:8i] of each energy bus and bit i of the fine-grain bus.

Top module: `eg_tower_judge`

## Requirements
- R1: A tower is considered good when its fine-grain bit is 1 and it passes the H/E test. The hit flag is 1 exactly when the centre tower (index 4) is good.
- R2: The H/E test passes when `had * 16 < em * frac`, where `frac` is the 4-bit `frac_i` read as a numerator over 16. The comparison is strict, so `frac = 0` fails every tower.
- R3: For a hit, the rank is the centre EM energy plus the largest EM energy among the north, south, east and west towers (indices 1, 7, 5, 3). A sum above 255 is reported as 255.
- R4: When the hit flag is 0, the rank output is 0.
- R5: The neighbours are quiet when all eight non-centre towers are good in the sense of R1.
- R6: There are four corner groups of five towers each: NW {0,1,2,3,6}, NE {0,1,2,5,8}, SW {0,3,6,7,8} and SE {2,5,6,7,8}. A group is quiet when the sum of its EM energies is strictly less than `corner_thr_i`.
- R7: The isolated flag is 1 exactly when the hit flag is 1, the neighbours are quiet and at least one corner group is quiet. It is never 1 without a hit.
- R8: A vector sampled with `in_valid` high produces `out_valid` high, with its results, two rising edges later. A cycle without `in_valid` produces `out_valid` low two edges later.
- R9: While reset is asserted, `out_valid`, `hit_o`, `rank_o` and `iso_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector valid |
| em_i | input | 72 | EM energies of the nine towers, 8 bits each, row-major |
| had_i | input | 72 | Hadronic energies of the nine towers, 8 bits each |
| fg_i | input | 9 | Fine-grain bits, one per tower |
| frac_i | input | 4 | H/E fraction numerator (in sixteenths) |
| corner_thr_i | input | 11 | Corner-group EM sum threshold |
| out_valid | output | 1 | Result valid |
| hit_o | output | 1 | Centre tower is a hit |
| rank_o | output | 8 | Candidate rank, saturated |
| iso_o | output | 1 | Candidate is isolated |

## Verification
Several decisions can land on the same vector and must be judged together. The most delicate case is a centre tower that fails its own hit test while its neighbours are quiet and a corner group is quiet. Here the zeroed rank and the forced-low isolated flag have to win over every other condition. Random vectors bias the hadronic energies low and the fine-grain bits high, so hits, misses, rank saturation and corner decisions all mix freely. Every output field is compared against a model in the bench, over a full sweep of the fraction numerator. Directed vectors place a corner sum exactly on the threshold and one below it, and push a rank sum past 255 while the candidate is also isolated.

// File: rtl/eg_tower_judge.sv
module eg_tower_judge #(
  parameter int EW = 8,
  parameter int FW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [9*EW-1:0]  em_i,
  input  logic [9*EW-1:0]  had_i,
  input  logic [8:0]       fg_i,
  input  logic [FW-1:0]    frac_i,
  input  logic [EW+2:0]    corner_thr_i,
  output logic             out_valid,
  output logic             hit_o,
  output logic [EW-1:0]    rank_o,
  output logic             iso_o
);
  localparam int NT = 9;
  localparam int SW = EW + 3;
  localparam int PW = EW + FW;
  localparam logic [EW-1:0] RMAX = {EW{1'b1}};

  logic [EW-1:0] e [NT];
  logic [NT-1:0] good;

  genvar i;
  generate
    for (i = 0; i < NT; i++) begin : g_tow
      logic [PW-1:0] lhs, rhs;
      assign e[i]    = em_i[i*EW +: EW];
      assign lhs     = {had_i[i*EW +: EW], {FW{1'b0}}};
      assign rhs     = PW'(e[i]) * PW'(frac_i);
      assign good[i] = fg_i[i] && (lhs < rhs);
    end
  endgenerate

  logic [EW-1:0] mx_ns, mx_we, mx;
  logic [EW:0]   rsum;
  logic [EW-1:0] rsat;
  assign mx_ns = (e[1] > e[7]) ? e[1] : e[7];
  assign mx_we = (e[3] > e[5]) ? e[3] : e[5];
  assign mx    = (mx_ns > mx_we) ? mx_ns : mx_we;
  assign rsum  = {1'b0, e[4]} + {1'b0, mx};
  assign rsat  = rsum[EW] ? RMAX : rsum[EW-1:0];

  logic [SW-1:0] c_nw, c_ne, c_sw, c_se;
  assign c_nw = SW'(e[0]) + SW'(e[1]) + SW'(e[2]) + SW'(e[3]) + SW'(e[6]);
  assign c_ne = SW'(e[0]) + SW'(e[1]) + SW'(e[2]) + SW'(e[5]) + SW'(e[8]);
  assign c_sw = SW'(e[0]) + SW'(e[3]) + SW'(e[6]) + SW'(e[7]) + SW'(e[8]);
  assign c_se = SW'(e[2]) + SW'(e[5]) + SW'(e[6]) + SW'(e[7]) + SW'(e[8]);

  logic quiet, corner_ok;
  assign quiet     = &{good[8:5], good[3:0]};
  assign corner_ok = (c_nw < corner_thr_i) || (c_ne < corner_thr_i) ||
                     (c_sw < corner_thr_i) || (c_se < corner_thr_i);

  logic          s1_v, s1_hit, s1_iso;
  logic [EW-1:0] s1_rank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_hit  <= 1'b0;
      s1_iso  <= 1'b0;
      s1_rank <= '0;
    end else begin
      s1_v    <= in_valid;
      s1_hit  <= good[4];
      s1_iso  <= quiet && corner_ok;
      s1_rank <= rsat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      hit_o     <= 1'b0;
      rank_o    <= '0;
      iso_o     <= 1'b0;
    end else begin
      out_valid <= s1_v;
      hit_o     <= s1_hit;
      rank_o    <= s1_hit ? s1_rank : '0;
      iso_o     <= s1_hit && s1_iso;
    end
  end

  assert_iso_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iso_o |-> hit_o);
  assert_rank_zero_nohit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> rank_o == '0);
  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  assert_idle_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  assert_rank_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hit_o) |-> rank_o >= $past(em_i[4*EW +: EW], 2));
  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !hit_o && !iso_o));
endmodule

// File: tb/eg_tower_judge_tb_top.sv
module eg_tower_judge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [71:0] em_i = '0, had_i = '0;
  logic [8:0]  fg_i = '0;
  logic [3:0]  frac_i = '0;
  logic [10:0] corner_thr_i = '0;
  logic        out_valid, hit_o, iso_o;
  logic [7:0]  rank_o;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eg_tower_judge dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .em_i(em_i),
    .had_i(had_i), .fg_i(fg_i), .frac_i(frac_i), .corner_thr_i(corner_thr_i),
    .out_valid(out_valid), .hit_o(hit_o), .rank_o(rank_o), .iso_o(iso_o));

  function automatic int emv(int k); return int'(em_i[8*k +: 8]); endfunction
  function automatic int hdv(int k); return int'(had_i[8*k +: 8]); endfunction
  function automatic bit good(int k);
    return fg_i[k] && (hdv(k) * 16 < emv(k) * int'(frac_i));
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply();
    int mx, r, t, cq;
    bit h, q, iso;
    int cs [4];
    h  = good(4);
    mx = emv(1);
    if (emv(7) > mx) mx = emv(7);
    if (emv(3) > mx) mx = emv(3);
    if (emv(5) > mx) mx = emv(5);
    r = emv(4) + mx;
    if (r > 255) r = 255;
    if (!h) r = 0;
    q = 1;
    for (int k = 0; k < 9; k++) if (k != 4 && !good(k)) q = 0;
    cs[0] = emv(0)+emv(1)+emv(2)+emv(3)+emv(6);
    cs[1] = emv(0)+emv(1)+emv(2)+emv(5)+emv(8);
    cs[2] = emv(0)+emv(3)+emv(6)+emv(7)+emv(8);
    cs[3] = emv(2)+emv(5)+emv(6)+emv(7)+emv(8);
    t = int'(corner_thr_i);
    cq = 0;
    for (int k = 0; k < 4; k++) if (cs[k] < t) cq = 1;
    iso = h && q && (cq != 0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 out_valid", int'(out_valid), 1);
    chk("R1 R2 hit", int'(hit_o), int'(h));
    chk("R3 R4 rank", int'(rank_o), r);
    chk("R5 R6 R7 iso", int'(iso_o), int'(iso));
    @(negedge clk);
    chk("R8 idle out_valid", int'(out_valid), 0);
  endtask

  task automatic set_em(int k, int v); em_i[8*k +: 8] = 8'(v); endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", int'(out_valid), 0);
    chk("R9 reset hit", int'(hit_o), 0);
    chk("R9 reset rank", int'(rank_o), 0);
    chk("R9 reset iso", int'(iso_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int f = 0; f < 16; f++) begin
      for (int n = 0; n < 64; n++) begin
        frac_i = 4'(f);
        for (int k = 0; k < 9; k++) begin
          em_i[8*k +: 8]  = 8'($urandom % 256);
          had_i[8*k +: 8] = 8'($urandom % (1 << ($urandom % 7)));
          fg_i[k]         = ($urandom % 8) != 0;
        end
        corner_thr_i = 11'($urandom % 1300);
        apply();
      end
    end
    // R6 threshold boundary: NW group sum equals threshold, others larger
    frac_i = 4'd15; had_i = '0; fg_i = '1;
    for (int k = 0; k < 9; k++) set_em(k, 20);
    set_em(5, 200); set_em(7, 200); set_em(8, 200);
    corner_thr_i = 11'd100;
    apply();
    corner_thr_i = 11'd101;
    apply();
    // R3 saturation together with isolation
    set_em(4, 200); set_em(1, 120); corner_thr_i = 11'd2000;
    apply();
    // R4 R7 non-hit centre with quiet neighbours and quiet corners
    fg_i[4] = 1'b0;
    apply();
    fg_i[4] = 1'b1; had_i[8*4 +: 8] = 8'd250;
    apply();
    // R2 frac zero fails everything
    had_i = '0; frac_i = 4'd0;
    apply();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule